// File: doc/BRIEF.md
# 8-bit ALU with selective status-flag update

This block is the arithmetic and logic unit of a small 8-bit accumulator processor. Each cycle it takes an operation code, the accumulator operand, a source operand and the current status flags. One clock edge later it presents the result byte and the new N, V, Z and C flags. It also presents a four-bit write mask that names the flags the operation was allowed to change.

Each operation owns a fixed set of flags. Any flag outside that set leaves the block with the value it came in with. The decode stage can therefore write the returned flags straight back into the status register. It can also use the mask to gate the write. The decimal flag is carried alongside the other flags with the same one-cycle delay and is never altered. No decimal correction is applied.

Increment, decrement, shifts and rotates act on the source operand, which may be a memory byte or a copy of the accumulator. Compare and bit test return the accumulator unchanged as the result.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `result`, `flags_out`, `flag_we` and `d_out` are all zero.
- R2: Every output reflects the inputs sampled at the previous rising clock edge. `d_out` equals the `d_in` sampled at that edge.
- R3: Op 0 (add) gives `acc + src + C`. C is the carry out of bit 7. V is set when both addends have the same sign and the sum has the other sign. N is result bit 7 and Z is set for a zero result. The mask is 4'b1111.
- R4: Op 1 (subtract) gives `acc + ~src + C`, so C acts as not-borrow. C, V, N and Z follow the rules of R3 applied to the inverted source, and the mask is 4'b1111.
- R5: Op 2 (AND), op 3 (OR) and op 4 (XOR) combine `acc` and `src` bitwise and change only N and Z. The mask is 4'b1010.
- R6: Op 7 gives `src + 1` and op 8 gives `src - 1`, both modulo 256. They change only N and Z, with mask 4'b1010.
- R7: Op 5 (compare) returns `acc` as the result. C is set when `acc >= src` (unsigned), Z when they are equal, and N is bit 7 of `acc - src`. The mask is 4'b1011.
- R8: Op 6 (bit test) returns `acc`. N takes `src[7]`, V takes `src[6]`, and Z is set when `acc & src` is zero. The mask is 4'b1110.
- R9: Op 9 shifts `src` left, putting bit 7 into C and 0 into bit 0. Op 11 rotates `src` left, putting C into bit 0 and bit 7 into C. Both set N and Z from the result and use mask 4'b1011.
- R10: Op 10 shifts `src` right, putting bit 0 into C and 0 into bit 7, so N is always cleared. Op 12 rotates `src` right, putting C into bit 7 and bit 0 into C. Both use mask 4'b1011.
- R11: Op codes 13 to 15 return `acc`, pass all flags through and drive mask 4'b0000.
- R12: Flag vectors are ordered {N,V,Z,C}, MSB first, matching status bits 7, 6, 1 and 0. Every `flags_out` bit whose `flag_we` bit is 0 equals the matching `flags_in` bit of the sampled cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator (or compared register) operand |
| src | input | 8 | Source operand |
| flags_in | input | 4 | Current {N,V,Z,C} |
| d_in | input | 1 | Current decimal flag |
| result | output | 8 | Registered result byte |
| flags_out | output | 4 | Registered new {N,V,Z,C} |
| flag_we | output | 4 | Registered write mask, {N,V,Z,C} order |
| d_out | output | 1 | Registered decimal flag, unchanged |

## Verification
Some properties are checked by assertions on every cycle:
- V and C keep their incoming values whenever their mask bit is clear.
- Logical shift right never leaves N set.
- Reserved codes drive an empty mask.
- The decimal flag arrives one cycle late without change.

Other properties are shown only by the bench's vectors and directed cases:
- The arithmetic itself: carry and overflow at the sign and byte boundaries, and borrow behaviour in subtract and compare.
- The exact N and Z values for each operation.
- The fact that compare and bit test leave the accumulator untouched.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW = 8;
    localparam int NF = 4;
    localparam int OPW = 4;

    localparam int FN = 3;
    localparam int FV = 2;
    localparam int FZ = 1;
    localparam int FC = 0;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_CMP = 4'd5,
        OP_BTS = 4'd6,
        OP_INC = 4'd7,
        OP_DEC = 4'd8,
        OP_SHL = 4'd9,
        OP_SHR = 4'd10,
        OP_RTL = 4'd11,
        OP_RTR = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        RT_LEFT  = 2'd2,
        RT_RIGHT = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic [NF-1:0] flags;
        logic [NF-1:0] we;
        logic          dec;
    } alu_out_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          ovf
);
    logic [DW-1:0] b_eff;
    logic [DW:0]   total;

    always_comb begin
        b_eff = sub ? ~b : b;
        total = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
        sum   = total[DW-1:0];
        cout  = total[DW];
        ovf   = (a[DW-1] == b_eff[DW-1]) && (total[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  logic [DW-1:0] val,
    input  logic          cin,
    input  shift_kind_e   kind,
    output logic [DW-1:0] res,
    output logic          cout
);
    always_comb begin
        case (kind)
            SH_LEFT: begin
                res  = {val[DW-2:0], 1'b0};
                cout = val[DW-1];
            end
            SH_RIGHT: begin
                res  = {1'b0, val[DW-1:1]};
                cout = val[0];
            end
            RT_LEFT: begin
                res  = {val[DW-2:0], cin};
                cout = val[DW-1];
            end
            default: begin
                res  = {cin, val[DW-1:1]};
                cout = val[0];
            end
        endcase
    end
endmodule

// File: rtl/alu8_flagmask.sv
module alu8_flagmask
    import alu8_pkg::*;
(
    input  logic [OPW-1:0] op,
    output logic [NF-1:0]  we
);
    always_comb begin
        case (op)
            OP_ADD, OP_SUB:                         we = 4'b1111;
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:  we = 4'b1010;
            OP_CMP, OP_SHL, OP_SHR, OP_RTL, OP_RTR: we = 4'b1011;
            OP_BTS:                                 we = 4'b1110;
            default:                                we = 4'b0000;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OPW-1:0]      op,
    input  logic [DW-1:0]       acc,
    input  logic [DW-1:0]       src,
    input  logic [NF-1:0]       flags_in,
    input  logic                d_in,
    output logic [DW-1:0]       result,
    output logic [NF-1:0]       flags_out,
    output logic [NF-1:0]       flag_we,
    output logic                d_out
);
    alu_out_t      out_d, out_q;
    logic [DW-1:0] as_sum, sh_res;
    logic          as_cout, as_ovf, sh_cout;
    logic          as_sub, as_cin;
    shift_kind_e   sh_kind;
    logic [NF-1:0] mask;

    always_comb begin
        as_sub = (op != OP_ADD);
        as_cin = (op == OP_CMP) ? 1'b1 : flags_in[FC];
        case (op)
            OP_SHL:  sh_kind = SH_LEFT;
            OP_SHR:  sh_kind = SH_RIGHT;
            OP_RTL:  sh_kind = RT_LEFT;
            default: sh_kind = RT_RIGHT;
        endcase
    end

    alu8_addsub u_addsub (
        .a    (acc),
        .b    (src),
        .sub  (as_sub),
        .cin  (as_cin),
        .sum  (as_sum),
        .cout (as_cout),
        .ovf  (as_ovf)
    );

    alu8_shift u_shift (
        .val  (src),
        .cin  (flags_in[FC]),
        .kind (sh_kind),
        .res  (sh_res),
        .cout (sh_cout)
    );

    alu8_flagmask u_mask (
        .op (op),
        .we (mask)
    );

    always_comb begin
        logic [DW-1:0] r;
        logic [NF-1:0] f;
        r = acc;
        f = flags_in;
        case (op)
            OP_ADD, OP_SUB: begin
                r = as_sum;
                f[FC] = as_cout;
                f[FV] = as_ovf;
            end
            OP_AND: r = acc & src;
            OP_OR:  r = acc | src;
            OP_XOR: r = acc ^ src;
            OP_INC: r = src + 1'b1;
            OP_DEC: r = src - 1'b1;
            OP_CMP: f[FC] = as_cout;
            OP_SHL, OP_SHR, OP_RTL, OP_RTR: begin
                r = sh_res;
                f[FC] = sh_cout;
            end
            default: ;
        endcase
        f[FN] = r[DW-1];
        f[FZ] = (r == '0);
        if (op == OP_CMP) begin
            f[FN] = as_sum[DW-1];
            f[FZ] = (as_sum == '0);
        end
        if (op == OP_BTS) begin
            f[FN] = src[DW-1];
            f[FV] = src[DW-2];
            f[FZ] = ((acc & src) == '0);
        end
        out_d.res   = r;
        out_d.flags = (f & mask) | (flags_in & ~mask);
        out_d.we    = mask;
        out_d.dec   = d_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result    = out_q.res;
    assign flags_out = out_q.flags;
    assign flag_we   = out_q.we;
    assign d_out     = out_q.dec;

    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R12
    keep_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !flag_we[FV]) |-> (flags_out[FV] == $past(flags_in[FV])));

    // R12
    keep_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !flag_we[FC]) |-> (flags_out[FC] == $past(flags_in[FC])));

    // R10
    shr_clears_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op) == OP_SHR) |-> !flags_out[FN]);

    // R2
    dec_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (d_out == $past(d_in)));

    // R11
    reserved_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op) > OP_RTR) |-> (flag_we == 4'b0000 && result == $past(acc)));
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] acc = '0;
    logic [7:0] src = '0;
    logic [3:0] flags_in = '0;
    logic       d_in = 1'b0;
    logic [7:0] result;
    logic [3:0] flags_out;
    logic [3:0] flag_we;
    logic       d_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu8_core u_dut (
        .clk (clk), .rst_n (rst_n), .op (op), .acc (acc), .src (src),
        .flags_in (flags_in), .d_in (d_in), .result (result),
        .flags_out (flags_out), .flag_we (flag_we), .d_out (d_out)
    );

    // {req, op, acc, src, flags_in, d, exp_result, exp_flags, exp_mask}
    localparam int NV = 20;
    localparam logic [44:0] VEC [NV] = '{
        {4'd3,  4'd0,  8'h50, 8'h50, 4'b0000, 1'b0, 8'hA0, 4'b1100, 4'b1111}, // R3 signed overflow
        {4'd3,  4'd0,  8'hFF, 8'h01, 4'b0001, 1'b1, 8'h01, 4'b0001, 4'b1111}, // R3 carry in
        {4'd3,  4'd0,  8'hFF, 8'h01, 4'b0000, 1'b0, 8'h00, 4'b0011, 4'b1111}, // R3 wrap to zero
        {4'd4,  4'd1,  8'h50, 8'hB0, 4'b0001, 1'b0, 8'hA0, 4'b1100, 4'b1111}, // R4 overflow, borrow
        {4'd4,  4'd1,  8'h05, 8'h03, 4'b0000, 1'b1, 8'h01, 4'b0001, 4'b1111}, // R4 borrow in
        {4'd5,  4'd2,  8'hF0, 8'h0F, 4'b0101, 1'b0, 8'h00, 4'b0111, 4'b1010}, // R5 AND
        {4'd5,  4'd3,  8'h80, 8'h01, 4'b0000, 1'b0, 8'h81, 4'b1000, 4'b1010}, // R5 OR
        {4'd5,  4'd4,  8'hFF, 8'hFF, 4'b1001, 1'b1, 8'h00, 4'b0011, 4'b1010}, // R5 XOR
        {4'd7,  4'd5,  8'h40, 8'h40, 4'b0100, 1'b0, 8'h40, 4'b0111, 4'b1011}, // R7 equal
        {4'd7,  4'd5,  8'h10, 8'h20, 4'b0000, 1'b0, 8'h10, 4'b1000, 4'b1011}, // R7 less
        {4'd7,  4'd5,  8'h80, 8'h7F, 4'b0000, 1'b0, 8'h80, 4'b0001, 4'b1011}, // R7 greater
        {4'd8,  4'd6,  8'h0F, 8'hC0, 4'b0001, 1'b0, 8'h0F, 4'b1111, 4'b1110}, // R8
        {4'd6,  4'd7,  8'h77, 8'hFF, 4'b0101, 1'b0, 8'h00, 4'b0111, 4'b1010}, // R6 inc wrap
        {4'd6,  4'd8,  8'h77, 8'h00, 4'b0000, 1'b0, 8'hFF, 4'b1000, 4'b1010}, // R6 dec wrap
        {4'd9,  4'd9,  8'h77, 8'h81, 4'b0000, 1'b0, 8'h02, 4'b0001, 4'b1011}, // R9 shift left
        {4'd10, 4'd10, 8'h77, 8'h01, 4'b1100, 1'b0, 8'h00, 4'b0111, 4'b1011}, // R10 shift right
        {4'd9,  4'd11, 8'h77, 8'h80, 4'b0001, 1'b0, 8'h01, 4'b0001, 4'b1011}, // R9 rotate left
        {4'd10, 4'd12, 8'h77, 8'h01, 4'b0001, 1'b0, 8'h80, 4'b1001, 4'b1011}, // R10 rotate right C in
        {4'd10, 4'd12, 8'h77, 8'h02, 4'b0100, 1'b0, 8'h01, 4'b0100, 4'b1011}, // R10 rotate right
        {4'd11, 4'd13, 8'h5A, 8'h33, 4'b1010, 1'b1, 8'h5A, 4'b1010, 4'b0000}  // R11 reserved
    };

    task automatic check(input string tag, input logic [7:0] er, input logic [3:0] ef,
                         input logic [3:0] em, input logic ed);
        checks++;
        if (result !== er || flags_out !== ef || flag_we !== em || d_out !== ed) begin
            fails++;
            $display("FAIL %s: res=%h flags=%b we=%b d=%b, expected res=%h flags=%b we=%b d=%b",
                     tag, result, flags_out, flag_we, d_out, er, ef, em, ed);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] s,
                         input logic [3:0] f, input logic d);
        op = o; acc = a; src = s; flags_in = f; d_in = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        op = 4'd4; acc = 8'hFF; src = 8'h00; flags_in = 4'b1111; d_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h00, 4'b0000, 4'b0000, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [44:0] v;
            v = VEC[i];
            apply(v[40:37], v[36:29], v[28:21], v[20:17], v[16]);
            check($sformatf("R%0d vector %0d", v[44:41], i), v[15:8], v[7:4], v[3:0], v[16]);
        end

        // R12 flags outside mask follow inputs: logic op with V and C both set
        apply(4'd3, 8'h00, 8'h00, 4'b0101, 1'b0);
        check("R12 keep V/C", 8'h00, 4'b0111, 4'b1010, 1'b0);
        // R11 top reserved code passes every flag through
        apply(4'd15, 8'hC3, 8'h00, 4'b1111, 1'b1);
        check("R11 code 15", 8'hC3, 4'b1111, 4'b0000, 1'b1);
        // R2 output holds the previous sample until the next edge
        op = 4'd0; acc = 8'h01; src = 8'h01; flags_in = 4'b0000; d_in = 1'b0;
        #3;
        check("R2 latency", 8'hC3, 4'b1111, 4'b0000, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R2 updated", 8'h02, 4'b0000, 4'b1111, 1'b0);
        // R4 subtract equal operands with C set gives zero and C
        apply(4'd1, 8'h33, 8'h33, 4'b0001, 1'b0);
        check("R4 zero", 8'h00, 4'b0011, 4'b1111, 1'b0);
        // R10 shift right of 0xFF clears N and sets C
        apply(4'd10, 8'h00, 8'hFF, 4'b1000, 1'b0);
        check("R10 N cleared", 8'h7F, 4'b0001, 4'b1011, 1'b0);
        // R1 reset in mid-run clears outputs
        rst_n = 1'b0;
        #2;
        check("R1 mid reset", 8'h00, 4'b0000, 4'b0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule